// File: doc/BRIEF.md
# Perfect Receive Address Filter

This block decides whether an incoming Ethernet frame should be kept, judging by its six-byte destination address. It holds a table of sixteen 48-bit station addresses that software fills by sending a setup frame: a byte stream of exactly 192 bytes split into sixteen 12-byte slots. Each slot carries one address spread over offsets 0, 1, 4, 5, 8 and 9, and all other bytes are padding. The new table replaces the old one only when the frame is complete. A frame that stops early or runs long changes nothing.

A lookup begins with a start strobe and the destination address. The block walks the table one entry per clock and then returns a one-cycle verdict: accept, filtering-fail and multicast. The verdict follows a fixed priority. Broadcast is checked first. Promiscuous or receive-all comes next, then pass-all-multicast, and last the perfect match, which can be inverted for exclusion lists. The four mode inputs are captured together with the address.

Addresses use the wire order in the low bits. The first byte on the wire is bits [7:0] and the sixth is bits [47:40], for both `query_addr` and table entries.

Top module: `paf_addr_filter`

## Requirements
- R1: After reset every table entry is all-zero and `res_valid` is low.
- R2: A setup frame of exactly 192 bytes replaces the whole table. Entry n receives bytes at offsets 0, 1, 4, 5, 8, 9 of 12-byte slot n as its address bytes 0 to 5 (bits [7:0] through [47:40]).
- R3: A setup frame whose `setup_last` byte is not byte 192, whether shorter or longer, leaves every entry unchanged.
- R4: `res_valid` is a one-cycle pulse that rises 17 clock cycles after the edge that samples `query_start`.
- R5: The all-ones address is accepted with both flags clear, whatever the modes.
- R6: Otherwise, if `mode_promisc` or `mode_rx_all` is set, the frame is accepted with `res_filt_fail` set and `res_mcast` clear.
- R7: Otherwise, if `mode_pass_mcast` is set and address bit 0 (LSB of the first byte) is 1, the frame is accepted with `res_mcast` set and `res_filt_fail` clear.
- R8: Otherwise the frame is accepted exactly when the address equals one of the 16 entries, and both flags are clear.
- R9: When `mode_inverse` is set, the outcome of R8 is inverted, and the flags stay clear.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Active-low synchronous reset |
| setup_valid | input | 1 | Setup frame byte valid |
| setup_last | input | 1 | Marks the final byte of a setup frame |
| setup_byte | input | 8 | Setup frame data byte |
| query_start | input | 1 | Starts a lookup; ignored while one is running |
| query_addr | input | 48 | Destination address, first wire byte in bits [7:0] |
| mode_promisc | input | 1 | Promiscuous mode |
| mode_rx_all | input | 1 | Receive-all mode |
| mode_pass_mcast | input | 1 | Pass all multicast addresses |
| mode_inverse | input | 1 | Inverse perfect filtering |
| res_valid | output | 1 | Verdict valid, one-cycle pulse |
| res_accept | output | 1 | Frame accepted |
| res_filt_fail | output | 1 | Accepted only because of promiscuous or receive-all |
| res_mcast | output | 1 | Accepted only because of pass-all-multicast |

## Verification
The bench checks the priority chain. It sends broadcast under promiscuous mode, which must still show no flags. It sends multicast under both promiscuous and pass-multicast, which must report filtering-fail rather than multicast. A design with the checks in the wrong order would raise the wrong flag or none. Setup frames one byte short and several bytes long follow a valid table, and old entries must still match. A design that writes bytes as they arrive would show a half-new table. The first and last table entries are both looked up, so an off-by-one walk that skips an end entry rejects a stored address. Every lookup is also timed, which exposes an extra or missing pipeline stage.

// File: rtl/paf_pkg.sv
package paf_pkg;
   typedef struct packed {
      logic inverse;
      logic pass_mcast;
      logic rx_all;
      logic promisc;
   } paf_mode_t;

   typedef struct packed {
      logic accept;
      logic filt_fail;
      logic mcast;
   } paf_verdict_t;
endpackage

// File: rtl/paf_setup_loader.sv
module paf_setup_loader #(
   parameter int N_ENT      = 16,
   parameter int ADDR_BYTES = 6,
   parameter int SLOT_BYTES = 12
) (
   input  logic                             clk,
   input  logic                             rst_n,
   input  logic                             in_valid,
   input  logic                             in_last,
   input  logic [7:0]                       in_byte,
   output logic [N_ENT*ADDR_BYTES*8-1:0]    table_flat
);
   localparam int AW     = ADDR_BYTES * 8;
   localparam int ENT_W  = (N_ENT > 1) ? $clog2(N_ENT) : 1;
   localparam int SLOT_W = $clog2(SLOT_BYTES);

   generate
      if (SLOT_BYTES != 2 * ADDR_BYTES) begin : g_bad_slot
         $error("slot must hold each address byte followed by two padding bytes per pair");
      end
   endgenerate

   logic [ENT_W-1:0]  slot_q;
   logic [SLOT_W-1:0] off_q;
   logic              over_q;
   logic [AW-1:0]     shadow [N_ENT];
   logic [AW-1:0]     live   [N_ENT];

   logic keep_byte, final_byte, commit;
   int   byte_idx;

   always_comb begin
      keep_byte  = (int'(off_q) % 4) < 2;
      byte_idx   = (int'(off_q) / 4) * 2 + (int'(off_q) % 4);
      final_byte = (int'(slot_q) == N_ENT - 1) && (int'(off_q) == SLOT_BYTES - 1) && !over_q;
      commit     = in_valid && in_last && final_byte;
   end

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         slot_q <= '0;
         off_q  <= '0;
         over_q <= 1'b0;
      end else if (in_valid) begin
         if (!over_q && keep_byte)
            shadow[slot_q][byte_idx*8 +: 8] <= in_byte;
         if (in_last) begin
            slot_q <= '0;
            off_q  <= '0;
            over_q <= 1'b0;
         end else if (final_byte) begin
            over_q <= 1'b1;
         end else if (!over_q) begin
            if (int'(off_q) == SLOT_BYTES - 1) begin
               off_q  <= '0;
               slot_q <= slot_q + 1'b1;
            end else begin
               off_q <= off_q + 1'b1;
            end
         end
      end
   end

   generate
      for (genvar e = 0; e < N_ENT; e++) begin : g_entry
         always_ff @(posedge clk) begin
            if (!rst_n)
               live[e] <= '0;
            else if (commit)
               live[e] <= shadow[e];
         end
         assign table_flat[e*AW +: AW] = live[e];
      end
   endgenerate

   // R3
   table_frozen_chk: assert property (@(posedge clk) disable iff (!rst_n)
      !$stable(table_flat) |-> $past(in_valid && in_last));
endmodule

// File: rtl/paf_match_seq.sv
module paf_match_seq
   import paf_pkg::*;
#(
   parameter int N_ENT = 16,
   parameter int AW    = 48
) (
   input  logic                 clk,
   input  logic                 rst_n,
   input  logic                 start,
   input  logic [AW-1:0]        addr,
   input  paf_mode_t            mode,
   input  logic [N_ENT*AW-1:0]  table_flat,
   output logic                 done,
   output logic                 hit,
   output logic [AW-1:0]        addr_q,
   output paf_mode_t            mode_q
);
   localparam int CW    = $clog2(N_ENT + 1);
   localparam int ENT_W = (N_ENT > 1) ? $clog2(N_ENT) : 1;

   logic          busy;
   logic [CW-1:0] cnt;
   logic [ENT_W-1:0] idx;
   logic [AW-1:0] cur_ent;

   assign idx     = cnt[ENT_W-1:0];
   assign cur_ent = table_flat[idx*AW +: AW];

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         busy   <= 1'b0;
         done   <= 1'b0;
         cnt    <= '0;
         hit    <= 1'b0;
         addr_q <= '0;
         mode_q <= '0;
      end else begin
         done <= 1'b0;
         if (!busy) begin
            if (start) begin
               busy   <= 1'b1;
               cnt    <= '0;
               hit    <= 1'b0;
               addr_q <= addr;
               mode_q <= mode;
            end
         end else if (int'(cnt) == N_ENT) begin
            busy <= 1'b0;
            done <= 1'b1;
         end else begin
            hit <= hit | (cur_ent == addr_q);
            cnt <= cnt + 1'b1;
         end
      end
   end

   // R4
   done_pulse_chk: assert property (@(posedge clk) disable iff (!rst_n)
      done |=> !done);
   // R4
   done_after_walk_chk: assert property (@(posedge clk) disable iff (!rst_n)
      done |-> $past(busy));
endmodule

// File: rtl/paf_decide.sv
module paf_decide
   import paf_pkg::*;
#(
   parameter int AW = 48
) (
   input  logic [AW-1:0] addr,
   input  paf_mode_t     mode,
   input  logic          hit,
   output paf_verdict_t  verdict
);
   always_comb begin
      verdict = '0;
      if (&addr) begin
         verdict.accept = 1'b1;
      end else if (mode.promisc || mode.rx_all) begin
         verdict.accept    = 1'b1;
         verdict.filt_fail = 1'b1;
      end else if (mode.pass_mcast && addr[0]) begin
         verdict.accept = 1'b1;
         verdict.mcast  = 1'b1;
      end else begin
         verdict.accept = hit ^ mode.inverse;
      end
   end
endmodule

// File: rtl/paf_addr_filter.sv
module paf_addr_filter
   import paf_pkg::*;
#(
   parameter int N_ENT      = 16,
   parameter int ADDR_BYTES = 6,
   parameter int SLOT_BYTES = 12
) (
   input  logic                    clk,
   input  logic                    rst_n,
   input  logic                    setup_valid,
   input  logic                    setup_last,
   input  logic [7:0]              setup_byte,
   input  logic                    query_start,
   input  logic [ADDR_BYTES*8-1:0] query_addr,
   input  logic                    mode_promisc,
   input  logic                    mode_rx_all,
   input  logic                    mode_pass_mcast,
   input  logic                    mode_inverse,
   output logic                    res_valid,
   output logic                    res_accept,
   output logic                    res_filt_fail,
   output logic                    res_mcast
);
   localparam int AW = ADDR_BYTES * 8;

   logic [N_ENT*AW-1:0] table_flat;
   logic                done, hit;
   logic [AW-1:0]       addr_q;
   paf_mode_t           mode_in, mode_q;
   paf_verdict_t        verdict;

   assign mode_in = '{inverse: mode_inverse, pass_mcast: mode_pass_mcast,
                      rx_all: mode_rx_all, promisc: mode_promisc};

   paf_setup_loader #(.N_ENT(N_ENT), .ADDR_BYTES(ADDR_BYTES), .SLOT_BYTES(SLOT_BYTES)) u_loader (
      .clk(clk), .rst_n(rst_n), .in_valid(setup_valid), .in_last(setup_last),
      .in_byte(setup_byte), .table_flat(table_flat));

   paf_match_seq #(.N_ENT(N_ENT), .AW(AW)) u_match (
      .clk(clk), .rst_n(rst_n), .start(query_start), .addr(query_addr), .mode(mode_in),
      .table_flat(table_flat), .done(done), .hit(hit), .addr_q(addr_q), .mode_q(mode_q));

   paf_decide #(.AW(AW)) u_decide (
      .addr(addr_q), .mode(mode_q), .hit(hit), .verdict(verdict));

   assign res_valid     = done;
   assign res_accept    = done & verdict.accept;
   assign res_filt_fail = done & verdict.filt_fail;
   assign res_mcast     = done & verdict.mcast;

   // R5
   bcast_clean_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (res_valid && (&addr_q)) |-> (res_accept && !res_filt_fail && !res_mcast));
   // R6
   flags_excl_chk: assert property (@(posedge clk) disable iff (!rst_n)
      res_valid |-> !(res_filt_fail && res_mcast));
   // R7
   mcast_needs_bit_chk: assert property (@(posedge clk) disable iff (!rst_n)
      res_mcast |-> (addr_q[0] && res_accept));
endmodule

// File: tb/test_paf_addr_filter.sv
module test_paf_addr_filter;
   localparam int CLK_P = 10;

   logic clk = 1'b0;
   logic rst_n = 1'b0;
   logic setup_valid = 1'b0, setup_last = 1'b0;
   logic [7:0] setup_byte = '0;
   logic query_start = 1'b0;
   logic [47:0] query_addr = '0;
   logic m_pr = 0, m_ra = 0, m_pm = 0, m_inv = 0;
   logic res_valid, res_accept, res_filt_fail, res_mcast;

   int n_run = 0, n_fail = 0;
   bit finished = 0;
   logic [47:0] ent [16];

   always #(CLK_P/2) clk = ~clk;

   paf_addr_filter i_paf_addr_filter (
      .clk(clk), .rst_n(rst_n), .setup_valid(setup_valid), .setup_last(setup_last),
      .setup_byte(setup_byte), .query_start(query_start), .query_addr(query_addr),
      .mode_promisc(m_pr), .mode_rx_all(m_ra), .mode_pass_mcast(m_pm), .mode_inverse(m_inv),
      .res_valid(res_valid), .res_accept(res_accept), .res_filt_fail(res_filt_fail),
      .res_mcast(res_mcast));

   typedef struct packed {
      logic [23:0] tag;
      logic [47:0] a;
      logic [3:0]  m;     // {inverse, pass_mcast, rx_all, promisc}
      logic [2:0]  exp;   // {accept, filt_fail, mcast}
   } vec_t;

   // table A entry i = bytes 02 11 22 33 44 (i+1)
   localparam vec_t VECS [13] = '{
      '{"R8 ", 48'h01_44_33_22_11_02, 4'b0000, 3'b100},  // first entry
      '{"R8 ", 48'h10_44_33_22_11_02, 4'b0000, 3'b100},  // last entry
      '{"R8 ", 48'h99_44_33_22_11_02, 4'b0000, 3'b000},  // unknown
      '{"R5 ", 48'hFF_FF_FF_FF_FF_FF, 4'b0000, 3'b100},
      '{"R5 ", 48'hFF_FF_FF_FF_FF_FF, 4'b1111, 3'b100},  // broadcast beats all
      '{"R6 ", 48'h99_44_33_22_11_02, 4'b0001, 3'b110},
      '{"R6 ", 48'h99_44_33_22_11_02, 4'b0010, 3'b110},
      '{"R7 ", 48'h01_44_33_22_11_03, 4'b0100, 3'b101},
      '{"R8 ", 48'h01_44_33_22_11_03, 4'b0000, 3'b000},
      '{"R6 ", 48'h01_44_33_22_11_03, 4'b0101, 3'b110},  // promisc beats mcast
      '{"R9 ", 48'h04_44_33_22_11_02, 4'b1000, 3'b000},
      '{"R9 ", 48'h99_44_33_22_11_02, 4'b1000, 3'b100},
      '{"R7 ", 48'h01_44_33_22_11_03, 4'b1100, 3'b101}   // mcast beats inverse
   };

   task automatic chk(input string req, input string what, input logic [47:0] act, input logic [47:0] exp);
      n_run++;
      if (act !== exp) begin
         n_fail++;
         $display("FAIL %s %s: actual %h expected %h", req, what, act, exp);
      end
   endtask

   task automatic send_setup(input int len, input logic [47:0] src [16]);
      for (int b = 0; b < len; b++) begin
         int s, o;
         s = (b / 12) % 16;
         o = b % 12;
         @(negedge clk);
         setup_valid = 1'b1;
         setup_last  = (b == len - 1);
         if (b < 192 && (o % 4) < 2)
            setup_byte = src[s][((o / 4) * 2 + (o % 4)) * 8 +: 8];
         else
            setup_byte = 8'hC3;
      end
      @(negedge clk);
      setup_valid = 1'b0;
      setup_last  = 1'b0;
   endtask

   task automatic query(input string req, input logic [47:0] a, input logic [3:0] m, input logic [2:0] exp);
      int lat;
      @(negedge clk);
      query_start = 1'b1;
      query_addr  = a;
      {m_inv, m_pm, m_ra, m_pr} = m;
      @(negedge clk);
      query_start = 1'b0;
      {m_inv, m_pm, m_ra, m_pr} = 4'b0000;
      query_addr  = '0;
      lat = 0;
      while (lat < 40) begin
         @(negedge clk);
         lat++;
         if (res_valid) break;
      end
      chk("R4", "latency", 48'(lat), 48'd17);
      chk(req, "verdict", 48'({res_accept, res_filt_fail, res_mcast}), 48'(exp));
      @(negedge clk);
      chk("R4", "pulse low", 48'(res_valid), 48'd0);
   endtask

   initial begin
      logic [47:0] tb_b [16];
      for (int i = 0; i < 16; i++) begin
         ent[i]  = {8'(i + 1), 40'h44_33_22_11_02};
         tb_b[i] = {8'h70 + 8'(i), 40'h0A_0B_0C_0D_2E};
      end
      repeat (3) @(negedge clk);
      // R1 reset state
      chk("R1", "res_valid after reset", 48'(res_valid), 48'd0);
      rst_n = 1'b1;
      query("R1", 48'h0, 4'b0000, 3'b100);
      query("R1", 48'h01_44_33_22_11_02, 4'b0000, 3'b000);
      // R3 short frame discarded
      send_setup(191, tb_b);
      query("R3", 48'h0, 4'b0000, 3'b100);
      query("R3", tb_b[0], 4'b0000, 3'b000);
      // R2 full load
      send_setup(192, ent);
      query("R2", 48'h0, 4'b0000, 3'b000);
      for (int v = 0; v < 13; v++)
         query(string'(VECS[v].tag), VECS[v].a, VECS[v].m, VECS[v].exp);
      // R3 long frame discarded
      send_setup(200, tb_b);
      query("R3", ent[7], 4'b0000, 3'b100);
      query("R3", tb_b[7], 4'b0000, 3'b000);
      // R2 reload replaces every entry
      send_setup(192, tb_b);
      query("R2", tb_b[0], 4'b0000, 3'b100);
      query("R2", tb_b[15], 4'b0000, 3'b100);
      query("R2", ent[15], 4'b0000, 3'b000);
      query("R9", ent[15], 4'b1000, 3'b100);
      if (!finished) begin
         finished = 1;
         $display("  [TB] %0d tests run, %0d failed", n_run, n_fail);
         $finish;
      end
   end

   initial begin
      #(CLK_P * 150000);
      if (!finished) begin
         finished = 1;
         n_run++;
         n_fail++;
         $display("FAIL watchdog: actual timeout expected completion");
         $display("  [TB] %0d tests run, %0d failed", n_run, n_fail);
         $finish;
      end
   end
endmodule